// File: doc/BRIEF.md
# Accumulator Machine Memory-Reference Executor

This block is the execution core of a 16-bit accumulator processor that carries a one-bit link flag beside the accumulator. Once started at a given address, it fetches instruction words from a synchronous single-port word memory and carries out each instruction. The instruction set covers loading an immediate value, jumping, storing, exchanging, increment-and-skip, subroutine call, the three bitwise operations, loading, adding, subtracting and compare-and-skip. Any memory-reference instruction can address memory directly or through a pointer word. A pointer kept in one of the eight auto-index words (absolute addresses 010 to 017) is incremented and written back before it is used.

The memory is outside the block. The core drives address, write data and write enable, and read data returns one clock after the address is presented. The program counter, accumulator, link and a running flag are visible at all times. A one-cycle `done` pulse marks the end of each instruction. The `cost` output gives that instruction's fixed architectural cost: 1 for immediate and stop, 2 for a direct reference, 3 for an indirect one. This figure does not depend on how many clocks the core actually spends.

The controller is a single state machine with these states: ST_IDLE, ST_FETCH, ST_DECODE, ST_PTR_RD, ST_PTR_UPD, ST_OPERAND and ST_EXECUTE. Its transitions are:
- ST_IDLE goes to ST_FETCH when `start` is high.
- ST_FETCH always goes to ST_DECODE.
- ST_DECODE returns to ST_FETCH for an immediate, moves to ST_IDLE for a stop, and otherwise goes to ST_PTR_RD (indirect) or ST_OPERAND (direct).
- ST_PTR_RD goes to ST_PTR_UPD.
- ST_PTR_UPD goes to ST_OPERAND.
- ST_OPERAND returns to ST_FETCH for jump, store and call, and otherwise goes to ST_EXECUTE.
- ST_EXECUTE returns to ST_FETCH.

Top module: `acc_mref_exec`

## Requirements
- R1: A synchronous reset clears pc, ac, link, running, done and cost to zero.
- R2: In idle, `start` loads pc from `start_pc` and sets running on the next clock. A `start` while running has no effect. The memory write enable is never high while idle.
- R3: Bit 15 of an instruction word is the indirect flag, bits 14..11 are the opcode and bits 10..0 are the address field. The block address is pc[15:11] joined with the address field. Opcodes: 0 and 15 stop, 1 load immediate, 2 load inverted immediate, 3 jump, 4 store, 5 exchange, 6 increment-and-skip, 7 call, 8 AND, 9 OR, 10 XOR, 11 load, 12 add, 13 subtract, 14 skip-if-equal.
- R4: Load immediate puts bits 7..0 of the word, zero-extended, into ac. Load inverted immediate puts the bitwise inverse of that value into ac. Both advance pc by one.
- R5: At each done pulse, cost is 1 for opcodes 0, 1, 2 and 15. For the other opcodes it is 2 when direct and 3 when indirect.
- R6: An indirect reference uses the word at the block address as the effective address. If the block address lies in 010..017, that word is first incremented modulo 2^16 and written back, and the incremented value is used.
- R7: Jump sets pc to the effective address. Store writes ac there. Exchange swaps ac with the word there.
- R8: Increment-and-skip writes the memory word plus one (modulo 2^16) back. It advances pc by two when the new value is zero and by one otherwise.
- R9: Call writes pc+1 to the effective address and sets pc to the effective address plus one.
- R10: Add puts ac+M modulo 2^16 into ac and inverts link on a carry out. Subtract puts ac−M modulo 2^16 into ac and inverts link when M exceeds ac. Otherwise link is kept.
- R11: AND, OR and XOR combine ac with M bitwise. Load copies M into ac. None of these four changes link.
- R12: Skip-if-equal advances pc by two when ac equals M and by one otherwise.
- R13: A stop opcode clears running, advances pc by one and returns to idle.
- R14: done is high for exactly one clock per instruction. pc, ac and link change only in a clock where done is high, apart from the load by `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin execution at start_pc (idle only) |
| start_pc | input | 16 | First instruction address |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| pc | output | 16 | Program counter |
| ac | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| running | output | 1 | High while instructions are being executed |
| done | output | 1 | One-cycle pulse at the end of each instruction |
| cost | output | 2 | Architectural cost of the instruction just finished |

## Verification
Two functions can land in a single clock, and each pairing is provoked on purpose. In ST_PTR_UPD, the auto-index pointer is written back to memory while the incremented value is captured as the effective address. In ST_EXECUTE, the exchange writes the old accumulator to memory while it loads the accumulator from the same word. Both cases are provoked by chaining a load and an exchange through pointer location 010. The result is judged by comparing the whole memory image, together with pc, ac and link, against a behavioural model at every done pulse, and the registers against the model on every clock.

// File: rtl/mref_pkg.sv
`timescale 1ns/1ps
package mref_pkg;

    typedef enum logic [3:0] {
        OP_STOP  = 4'd0,
        OP_LDI   = 4'd1,
        OP_LDN   = 4'd2,
        OP_JMP   = 4'd3,
        OP_STA   = 4'd4,
        OP_XCH   = 4'd5,
        OP_ISZ   = 4'd6,
        OP_CAL   = 4'd7,
        OP_AND   = 4'd8,
        OP_IOR   = 4'd9,
        OP_XOR   = 4'd10,
        OP_LDA   = 4'd11,
        OP_ADD   = 4'd12,
        OP_SUB   = 4'd13,
        OP_SKE   = 4'd14,
        OP_STOPX = 4'd15
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_PTR_RD,
        ST_PTR_UPD,
        ST_OPERAND,
        ST_EXECUTE
    } st_e;

endpackage

// File: rtl/mref_decode.sv
`timescale 1ns/1ps
module mref_decode
    import mref_pkg::*;
#(
    parameter int unsigned WORD_W       = 16,
    parameter int unsigned ADDR_FIELD_W = 11,
    parameter int unsigned IMM_W        = 8
) (
    input  logic [WORD_W-1:0]            word,
    input  logic [WORD_W-ADDR_FIELD_W-1:0] pc_hi,
    output op_e                          op,
    output logic                         ind,
    output logic [WORD_W-1:0]            blk_addr,
    output logic [WORD_W-1:0]            imm_val,
    output logic [1:0]                   cost
);
    localparam int unsigned OPC_LSB = ADDR_FIELD_W;

    assign op       = op_e'(word[OPC_LSB +: 4]);
    assign ind      = word[WORD_W-1];
    assign blk_addr = {pc_hi, word[ADDR_FIELD_W-1:0]};
    assign imm_val  = {{(WORD_W-IMM_W){1'b0}}, word[IMM_W-1:0]};

    always_comb begin
        unique case (op)
            OP_STOP, OP_STOPX, OP_LDI, OP_LDN: cost = 2'd1;
            default:                           cost = ind ? 2'd3 : 2'd2;
        endcase
    end
endmodule

// File: rtl/mref_alu.sv
`timescale 1ns/1ps
module mref_alu
    import mref_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  op_e               op,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] opnd,
    input  logic              lnk,
    output logic [WORD_W-1:0] acc_n,
    output logic              lnk_n,
    output logic [WORD_W-1:0] mem_n,
    output logic              skip
);
    logic [WORD_W:0]   sum;
    logic [WORD_W-1:0] bumped;

    assign sum    = {1'b0, acc} + {1'b0, opnd};
    assign bumped = opnd + {{(WORD_W-1){1'b0}}, 1'b1};

    always_comb begin
        acc_n = acc;
        lnk_n = lnk;
        mem_n = acc;
        skip  = 1'b0;
        case (op)
            OP_XCH: begin acc_n = opnd; mem_n = acc; end
            OP_ISZ: begin mem_n = bumped; skip = (bumped == '0); end
            OP_AND: acc_n = acc & opnd;
            OP_IOR: acc_n = acc | opnd;
            OP_XOR: acc_n = acc ^ opnd;
            OP_LDA: acc_n = opnd;
            OP_ADD: begin acc_n = sum[WORD_W-1:0]; lnk_n = lnk ^ sum[WORD_W]; end
            OP_SUB: begin acc_n = acc - opnd; lnk_n = lnk ^ (opnd > acc); end
            OP_SKE: skip = (acc == opnd);
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_mref_exec.sv
`timescale 1ns/1ps
module acc_mref_exec
    import mref_pkg::*;
#(
    parameter int unsigned WORD_W       = 16,
    parameter int unsigned ADDR_FIELD_W = 11,
    parameter int unsigned IMM_W        = 8,
    parameter int unsigned AUTO_BASE    = 8,
    parameter int unsigned AUTO_COUNT   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] start_pc,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] ac,
    output logic              link,
    output logic              running,
    output logic              done,
    output logic [1:0]        cost
);
    localparam logic [WORD_W-1:0] ONE     = WORD_W'(1);
    localparam logic [WORD_W-1:0] TWO     = WORD_W'(2);
    localparam logic [WORD_W-1:0] AUTO_LO = WORD_W'(AUTO_BASE);
    localparam logic [WORD_W-1:0] AUTO_HI = WORD_W'(AUTO_BASE + AUTO_COUNT - 1);

    st_e               state, nxt;
    logic [WORD_W-1:0] ir, ea;
    logic [WORD_W-1:0] dec_word, dec_blk, dec_imm;
    op_e               dec_op;
    logic              dec_ind;
    logic [1:0]        dec_cost;
    logic [WORD_W-1:0] alu_acc, alu_mem;
    logic              alu_lnk, alu_skip;
    logic              auto_hit;
    logic [WORD_W-1:0] ptr_next;

    assign dec_word = (state == ST_DECODE) ? mem_rdata : ir;
    assign auto_hit = (ea >= AUTO_LO) && (ea <= AUTO_HI);
    assign ptr_next = mem_rdata + ONE;

    mref_decode #(.WORD_W(WORD_W), .ADDR_FIELD_W(ADDR_FIELD_W), .IMM_W(IMM_W)) u_dec (
        .word     (dec_word),
        .pc_hi    (pc[WORD_W-1:ADDR_FIELD_W]),
        .op       (dec_op),
        .ind      (dec_ind),
        .blk_addr (dec_blk),
        .imm_val  (dec_imm),
        .cost     (dec_cost)
    );

    mref_alu #(.WORD_W(WORD_W)) u_alu (
        .op    (dec_op),
        .acc   (ac),
        .opnd  (mem_rdata),
        .lnk   (link),
        .acc_n (alu_acc),
        .lnk_n (alu_lnk),
        .mem_n (alu_mem),
        .skip  (alu_skip)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = start ? ST_FETCH : ST_IDLE;
            ST_FETCH:   nxt = ST_DECODE;
            ST_DECODE: begin
                if (dec_op == OP_STOP || dec_op == OP_STOPX)     nxt = ST_IDLE;
                else if (dec_op == OP_LDI || dec_op == OP_LDN)   nxt = ST_FETCH;
                else if (dec_ind)                                nxt = ST_PTR_RD;
                else                                             nxt = ST_OPERAND;
            end
            ST_PTR_RD:  nxt = ST_PTR_UPD;
            ST_PTR_UPD: nxt = ST_OPERAND;
            ST_OPERAND: nxt = (dec_op == OP_JMP || dec_op == OP_STA || dec_op == OP_CAL)
                              ? ST_FETCH : ST_EXECUTE;
            ST_EXECUTE: nxt = ST_FETCH;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Memory port
    always_comb begin
        mem_addr  = pc;
        mem_wdata = ac;
        mem_we    = 1'b0;
        case (state)
            ST_PTR_RD:  mem_addr = ea;
            ST_PTR_UPD: begin
                mem_addr  = ea;
                mem_wdata = ptr_next;
                mem_we    = auto_hit;
            end
            ST_OPERAND: begin
                mem_addr = ea;
                if (dec_op == OP_STA) begin
                    mem_we = 1'b1;
                end else if (dec_op == OP_CAL) begin
                    mem_we    = 1'b1;
                    mem_wdata = pc + ONE;
                end
            end
            ST_EXECUTE: begin
                mem_addr  = ea;
                mem_wdata = alu_mem;
                mem_we    = (dec_op == OP_XCH) || (dec_op == OP_ISZ);
            end
            default: ;
        endcase
    end

    // Architectural registers and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            ac      <= '0;
            link    <= 1'b0;
            running <= 1'b0;
            done    <= 1'b0;
            cost    <= 2'd0;
            ir      <= '0;
            ea      <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc      <= start_pc;
                        running <= 1'b1;
                    end
                end
                ST_FETCH: ;
                ST_DECODE: begin
                    ir <= mem_rdata;
                    ea <= dec_blk;
                    case (dec_op)
                        OP_LDI: begin
                            ac <= dec_imm; pc <= pc + ONE; done <= 1'b1; cost <= dec_cost;
                        end
                        OP_LDN: begin
                            ac <= ~dec_imm; pc <= pc + ONE; done <= 1'b1; cost <= dec_cost;
                        end
                        OP_STOP, OP_STOPX: begin
                            running <= 1'b0; pc <= pc + ONE; done <= 1'b1; cost <= dec_cost;
                        end
                        default: ;
                    endcase
                end
                ST_PTR_RD: ;
                ST_PTR_UPD: ea <= auto_hit ? ptr_next : mem_rdata;
                ST_OPERAND: begin
                    case (dec_op)
                        OP_JMP: begin pc <= ea;       done <= 1'b1; cost <= dec_cost; end
                        OP_STA: begin pc <= pc + ONE; done <= 1'b1; cost <= dec_cost; end
                        OP_CAL: begin pc <= ea + ONE; done <= 1'b1; cost <= dec_cost; end
                        default: ;
                    endcase
                end
                ST_EXECUTE: begin
                    ac   <= alu_acc;
                    link <= alu_lnk;
                    pc   <= pc + (alu_skip ? TWO : ONE);
                    done <= 1'b1;
                    cost <= dec_cost;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mref_exec_chk.sv
`timescale 1ns/1ps
module mref_exec_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mem_we,
    input logic [WORD_W-1:0] pc,
    input logic [WORD_W-1:0] ac,
    input logic              link,
    input logic              running,
    input logic              done,
    input logic [1:0]        cost
);
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !running |-> !mem_we);

    p_run_from_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(start));

    p_cost_range_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (cost != 2'd0));

    p_stop_ends_r13: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> done);

    p_done_pulse_r14: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_pc_hold_r14: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(start)) |-> $stable(pc));

    p_acc_hold_r14: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(ac) && $stable(link)));
endmodule

bind acc_mref_exec mref_exec_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mem_we  (mem_we),
    .pc      (pc),
    .ac      (ac),
    .link    (link),
    .running (running),
    .done    (done),
    .cost    (cost)
);

// File: tb/acc_mref_exec_tb.sv
`timescale 1ns/1ps
module acc_mref_exec_tb;
    logic        clk = 1'b0;
    logic        rst, start;
    logic [15:0] start_pc;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;
    logic [15:0] pc, ac;
    logic        link, running, done;
    logic [1:0]  cost;

    always #5 clk = ~clk;

    acc_mref_exec u_dut (
        .clk(clk), .rst(rst), .start(start), .start_pc(start_pc),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .pc(pc), .ac(ac), .link(link), .running(running), .done(done), .cost(cost)
    );

    // Bench memory (2048 words, address aliased on bits 10..0)
    logic [15:0] mem [0:2047];
    logic        clr, ld;
    logic [10:0] ld_a;
    logic [15:0] ld_d;

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 16'd0;
        end else if (ld) begin
            mem[ld_a] <= ld_d;
        end else if (mem_we) begin
            mem[mem_addr[10:0]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[10:0]];
    end

    function automatic bit differs(string tag, string what, logic [15:0] act, logic [15:0] exp);
        if (act !== exp) begin
            $display("FAIL %s %s: actual=%0o expected=%0o", tag, what, act, exp);
            return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic string tag_of(int op, bit ind);
        if (ind && op > 2 && op < 15) return "R6";
        case (op)
            0, 15:     return "R13";
            1, 2:      return "R4";
            3, 4, 5:   return "R7";
            6:         return "R8";
            7:         return "R9";
            12, 13:    return "R10";
            14:        return "R12";
            default:   return "R11";
        endcase
    endfunction

    // Behavioural reference model
    logic [15:0] mm [0:2047];
    logic [15:0] mpc = 16'd0, mac = 16'd0;
    logic        ml = 1'b0, mrun = 1'b0;
    logic [1:0]  mcost = 2'd0;
    int          mop = 0;
    bit          mind = 1'b0;
    bit          chk_on = 1'b0;
    bit          prev_done = 1'b0;
    int          mchk = 0, merr = 0;

    task automatic model_step();
        logic [15:0] w, ba, ea, nxt, m, t;
        logic [16:0] s;
        w    = mm[mpc[10:0]];
        mop  = int'(w[14:11]);
        mind = w[15];
        ba   = {mpc[15:11], w[10:0]};
        nxt  = mpc + 16'd1;
        if (mop == 0 || mop == 15) begin
            mrun = 1'b0; mcost = 2'd1;
        end else if (mop == 1) begin
            mac = {8'd0, w[7:0]}; mcost = 2'd1;
        end else if (mop == 2) begin
            mac = ~{8'd0, w[7:0]}; mcost = 2'd1;
        end else begin
            mcost = mind ? 2'd3 : 2'd2;
            ea = ba;
            if (mind) begin
                if (ba >= 16'o10 && ba <= 16'o17) mm[ba[10:0]] = mm[ba[10:0]] + 16'd1;
                ea = mm[ba[10:0]];
            end
            m = mm[ea[10:0]];
            case (mop)
                3:  nxt = ea;
                4:  mm[ea[10:0]] = mac;
                5:  begin t = mac; mac = m; mm[ea[10:0]] = t; end
                6:  begin mm[ea[10:0]] = m + 16'd1; if (m == 16'o177777) nxt = mpc + 16'd2; end
                7:  begin mm[ea[10:0]] = mpc + 16'd1; nxt = ea + 16'd1; end
                8:  mac = mac & m;
                9:  mac = mac | m;
                10: mac = mac ^ m;
                11: mac = m;
                12: begin s = {1'b0, mac} + {1'b0, m}; mac = s[15:0]; if (s[16]) ml = ~ml; end
                13: begin if (m > mac) ml = ~ml; mac = mac - m; end
                default: if (mac == m) nxt = mpc + 16'd2;
            endcase
        end
        mpc = nxt;
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            string tg;
            tg = "R14";
            if (done) begin
                mchk++; merr += differs("R14", "done width", {15'd0, prev_done}, 16'd0);
                model_step();
                tg = tag_of(mop, mind);
                mchk++; merr += differs("R5", "cost", {14'd0, cost}, {14'd0, mcost});
                begin
                    bit bad;
                    bad = 1'b0;
                    for (int i = 0; i < 2048; i++) begin
                        if (!bad && mem[i] !== mm[i]) begin
                            bad = 1'b1;
                            $display("FAIL %s memory[%0o]: actual=%0o expected=%0o", tg, i, mem[i], mm[i]);
                        end
                    end
                    mchk++; if (bad) merr++;
                end
            end
            mchk++; merr += differs(tg, "pc", pc, mpc);
            mchk++; merr += differs(tg, "ac", ac, mac);
            mchk++; merr += differs(tg, "link", {15'd0, link}, {15'd0, ml});
            mchk++; merr += differs(tg, "running", {15'd0, running}, {15'd0, mrun});
            prev_done = done;
        end
        if (clr) for (int i = 0; i < 2048; i++) mm[i] = 16'd0;
        if (ld) mm[ld_a] = ld_d;
        if (start && !mrun) begin
            mpc  = start_pc;
            mrun = 1'b1;
        end
    end

    // Directed checks
    int tchk = 0, terr = 0;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        tchk++;
        terr += differs(tag, what, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wipe();
        clr = 1'b1; tick(); clr = 1'b0;
    endtask

    task automatic put(logic [15:0] a, logic [15:0] d);
        ld = 1'b1; ld_a = a[10:0]; ld_d = d; tick(); ld = 1'b0;
    endtask

    function automatic logic [15:0] enc(bit i, int op, int a);
        logic [3:0]  o;
        logic [10:0] f;
        o = op[3:0];
        f = a[10:0];
        return {i, o, f};
    endfunction

    task automatic run_prog(logic [15:0] a, bit poke);
        int n;
        start = 1'b1; start_pc = a; tick(); start = 1'b0;
        chk("R2", "pc after start", pc, a);
        chk("R2", "running after start", {15'd0, running}, 16'd1);
        if (poke) begin
            tick(); tick(); tick();
            start = 1'b1; start_pc = 16'o777; tick(); start = 1'b0;
        end
        n = 0;
        while (running && n < 3000) begin tick(); n++; end
        if (running) begin
            tchk++; terr++;
            $display("FAIL R13 program at %0o: actual=running expected=stopped", a);
        end
        tick(); tick();
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; start_pc = 16'd0; clr = 1'b0; ld = 1'b0; ld_a = '0; ld_d = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1", "pc", pc, 16'd0);
        chk("R1", "ac", ac, 16'd0);
        chk("R1", "link", {15'd0, link}, 16'd0);
        chk("R1", "running", {15'd0, running}, 16'd0);
        chk("R1", "done", {15'd0, done}, 16'd0);
        chk("R1", "cost", {14'd0, cost}, 16'd0);
        chk_on = 1'b1;
        wipe();

        // P1: immediates (R4), stop (R13)
        put(16'o100, enc(0, 1, 11'o1777));
        put(16'o101, enc(0, 4, 11'o300));
        put(16'o102, enc(0, 2, 1));
        put(16'o103, enc(0, 4, 11'o301));
        put(16'o104, enc(0, 2, 0));
        put(16'o105, enc(0, 0, 0));
        run_prog(16'o100, 1'b0);
        chk("R4", "zero-extended immediate", mem[11'o300], 16'o377);
        chk("R4", "inverted immediate 1", mem[11'o301], 16'o177776);
        chk("R4", "inverted immediate 0", ac, 16'o177777);
        chk("R13", "pc after stop", pc, 16'o106);

        // P2: add / subtract link toggling (R10)
        wipe();
        put(16'o100, enc(0, 2, 0));
        put(16'o101, enc(0, 12, 11'o200));
        put(16'o102, enc(0, 12, 11'o200));
        put(16'o103, enc(0, 2, 0));
        put(16'o104, enc(0, 12, 11'o200));
        put(16'o105, enc(0, 13, 11'o201));
        put(16'o106, enc(0, 1, 2));
        put(16'o107, enc(0, 13, 11'o202));
        put(16'o110, enc(0, 0, 0));
        put(16'o200, 16'd1); put(16'o201, 16'd1); put(16'o202, 16'd2);
        run_prog(16'o100, 1'b0);
        chk("R10", "ac after 2-2", ac, 16'd0);
        chk("R10", "link after toggles", {15'd0, link}, 16'd1);

        // P3: indirect with auto-index (R6, R7)
        wipe();
        put(16'o10, 16'o117); put(16'o120, 16'o55); put(16'o121, 16'o7); put(16'o110, 16'o122);
        put(16'o100, enc(1, 11, 11'o10));
        put(16'o101, enc(1, 5, 11'o10));
        put(16'o102, enc(1, 4, 11'o110));
        put(16'o103, enc(0, 0, 0));
        run_prog(16'o100, 1'b0);
        chk("R6", "auto pointer written back", mem[11'o10], 16'o121);
        chk("R6", "plain pointer untouched", mem[11'o110], 16'o122);
        chk("R7", "exchange memory side", mem[11'o121], 16'o55);
        chk("R7", "store through plain pointer", mem[11'o122], 16'o7);
        chk("R7", "exchange ac side", ac, 16'o7);

        // P4: increment-and-skip (R8), start ignored while running (R2)
        wipe();
        put(16'o200, 16'o177776);
        put(16'o100, enc(0, 6, 11'o200));
        put(16'o101, enc(0, 6, 11'o200));
        put(16'o102, enc(0, 1, 1));
        put(16'o103, enc(0, 1, 2));
        put(16'o104, enc(0, 0, 0));
        run_prog(16'o100, 1'b1);
        chk("R8", "wrapped word", mem[11'o200], 16'd0);
        chk("R8", "skipped load", ac, 16'd2);
        chk("R2", "pc unaffected by start while running", pc, 16'o105);

        // P5: call, indirect jump, skip-if-equal (R9, R7, R12)
        wipe();
        put(16'o100, enc(0, 7, 11'o150));
        put(16'o151, enc(0, 1, 5));
        put(16'o152, enc(1, 3, 11'o153));
        put(16'o153, 16'o110);
        put(16'o110, enc(0, 14, 11'o160));
        put(16'o111, enc(0, 15, 0));
        put(16'o112, enc(0, 14, 11'o161));
        put(16'o113, enc(0, 0, 0));
        put(16'o160, 16'd5); put(16'o161, 16'd6);
        run_prog(16'o100, 1'b0);
        chk("R9", "return address stored", mem[11'o150], 16'o101);
        chk("R12", "pc after equal skip and no skip", pc, 16'o114);

        // P6: bitwise and load, link kept (R11)
        wipe();
        put(16'o100, enc(0, 2, 0));
        put(16'o101, enc(0, 8, 11'o200));
        put(16'o102, enc(0, 9, 11'o201));
        put(16'o103, enc(0, 10, 11'o202));
        put(16'o104, enc(0, 4, 11'o300));
        put(16'o105, enc(0, 11, 11'o203));
        put(16'o106, enc(0, 15, 0));
        put(16'o200, 16'o52525); put(16'o201, 16'o125252); put(16'o202, 16'd1); put(16'o203, 16'o123);
        run_prog(16'o100, 1'b0);
        chk("R11", "and/or/xor result", mem[11'o300], 16'o177776);
        chk("R11", "load result", ac, 16'o123);
        chk("R11", "link unchanged", {15'd0, link}, 16'd1);

        // P7: block address from pc high bits (R3)
        wipe();
        put(16'o100, enc(0, 3, 11'o200));
        put(16'o200, enc(0, 0, 0));
        run_prog(16'o4100, 1'b0);
        chk("R3", "jump stays in block 1", pc, 16'o4201);

        $display("Result: errors=%0d of %0d checks", terr + merr, tchk + mchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", terr + merr + 1, tchk + mchk + 1);
        $finish;
    end
endmodule